// File: doc/BRIEF.md
# Receive Polarity Detect and Lock

This block decides whether the receive twisted pair is wired reversed and drives an invert control for the receive data path. It learns the polarity from two kinds of evidence. One is the link test pulses that arrive while the link is idle. The other is the polarity of the end-of-frame delimiter that the decoder reports at the end of each valid frame. While unlocked, the latest link pulse sets the invert flag. A frame whose delimiter disagrees with the current setting overrides it. When two consecutive frames agree, the setting freezes. It stays frozen until reset or until the link integrity logic reports a link failure.

The same block tracks the link-failed condition. While the link is failed, link pulses of either polarity are counted. A run of five consecutive pulses of one polarity ends the failed condition, and the block reports this with a single-cycle exit strobe. A disable input turns correction off, which keeps the data path uninverted and the lock clear.

The block is fully synchronous, with a synchronous active-high reset. Every output is a register, so each one changes on the clock edge that samples its cause.

Top module: `rxpol_ctrl`

## Requirements
- R1: After reset, `rx_invert`, `pol_locked` and `lf_exit_stb` are 0, and the link is in the failed condition.
- R2: While the link is failed and `link_fail` is low, every `lp_stb` counts as a link pulse of either polarity. When five consecutive pulses share one `lp_neg` value, `lf_exit_stb` is 1 for exactly the one cycle after the edge that samples the fifth pulse, and the link is then up.
- R3: A link pulse whose `lp_neg` differs from the previous pulse restarts the consecutive count at one.
- R4: While the link is up, link pulses never raise `lf_exit_stb`.
- R5: While unlocked, enabled and with no frame strobe in the same cycle, a link pulse sets `rx_invert` to its `lp_neg` value (1 means the pair appears reversed) at the next edge.
- R6: While unlocked and enabled, a frame strobe whose `eof_neg` differs from `rx_invert` loads `rx_invert` with `eof_neg` and restarts the agreement count at one. A matching frame adds one to the count. `pol_locked` rises at the edge where the count reaches two.
- R7: While `pol_locked` is 1, neither link pulses nor frame strobes change `rx_invert`.
- R8: `link_fail` high clears `pol_locked` and the agreement count at the next edge, returns the link to the failed condition and leaves `rx_invert` unchanged. Strobes in that cycle have no effect.
- R9: When `lp_stb` and `eof_stb` are both high in one cycle while unlocked, the frame alone decides `rx_invert`.
- R10: `corr_dis` high forces `rx_invert` and `pol_locked` to 0 at the next edge and holds them there while it stays high. Link-fail tracking and `lf_exit_stb` still work while it is high.
- R11: Reset is synchronous and restores the R1 state even from a locked condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_stb | input | 1 | One-cycle strobe: a valid link test pulse was seen |
| lp_neg | input | 1 | Polarity of that pulse, 1 = appears reversed |
| eof_stb | input | 1 | One-cycle strobe: a valid frame ended with a delimiter |
| eof_neg | input | 1 | Polarity of that delimiter, 1 = appears reversed |
| link_fail | input | 1 | Link integrity logic reports link failure |
| corr_dis | input | 1 | 1 disables polarity correction |
| rx_invert | output | 1 | Invert control for the receive data path |
| pol_locked | output | 1 | Polarity is frozen |
| lf_exit_stb | output | 1 | One-cycle strobe: link-failed condition left |

## Verification
A wrong agreement count shows up as `pol_locked` rising one frame early or late, and that is visible at the edge after the second frame. A run counter that fails to restart on a polarity change raises `lf_exit_stb` after a mixed sequence of pulses, at the edge after the offending pulse. A lock that does not truly freeze shows up as `rx_invert` following a disagreeing frame or pulse one cycle later. The bench steps through sequences that separate these cases: a polarity change just before the fifth pulse, alternating delimiters, both strobes in one cycle, and disable together with link failure. It compares every output on every cycle.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    localparam int unsigned DEF_EXIT_PULSES = 5;
    localparam int unsigned DEF_LOCK_FRAMES = 2;

    typedef struct packed {
        logic stb;
        logic neg;
    } pol_evt_t;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_st_e;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic evt_agrees(pol_evt_t e, logic cur);
        return e.neg == cur;
    endfunction

endpackage

// File: rtl/rxpol_linkexit.sv
module rxpol_linkexit
    import rxpol_pkg::*;
#(
    parameter int unsigned EXIT_PULSES = DEF_EXIT_PULSES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     link_fail,
    input  pol_evt_t lp,
    output logic     exit_stb
);

    localparam int unsigned RW = cnt_w(EXIT_PULSES);
    localparam logic [RW-1:0] RUN_ONE  = RW'(1);
    localparam logic [RW-1:0] RUN_LAST = RW'(EXIT_PULSES);

    link_st_e      st_q;
    logic [RW-1:0] run_q;
    logic          last_q;
    logic          exit_q;

    logic          same_run;
    logic [RW-1:0] run_inc;
    logic          run_hit;
    logic          lp_seen;

    assign lp_seen  = lp.stb;
    assign same_run = (run_q != '0) && (lp.neg == last_q);
    assign run_inc  = same_run ? run_q + RUN_ONE : RUN_ONE;
    assign run_hit  = (run_inc == RUN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LINK_DOWN;
            run_q  <= '0;
            last_q <= 1'b0;
            exit_q <= 1'b0;
        end else begin
            exit_q <= 1'b0;
            if (link_fail) begin
                st_q  <= LINK_DOWN;
                run_q <= '0;
            end else if (st_q == LINK_DOWN && lp.stb) begin
                last_q <= lp.neg;
                if (run_hit) begin
                    st_q   <= LINK_UP;
                    run_q  <= '0;
                    exit_q <= 1'b1;
                end else begin
                    run_q <= run_inc;
                end
            end
        end
    end

    assign exit_stb = exit_q;

    // R2: an exit strobe is always caused by a pulse on the previous edge
    a_r2_exit_after_pulse: assert property (@(posedge clk) disable iff (rst)
        exit_q |-> $past(lp_seen));

    // R2: the exit strobe lasts a single cycle
    a_r2_exit_single: assert property (@(posedge clk) disable iff (rst)
        exit_q |=> !exit_q);

    // R4: no exit while the link is already up
    a_r4_no_exit_when_up: assert property (@(posedge clk) disable iff (rst)
        (st_q == LINK_UP && !link_fail) |=> !exit_q);

    // R3: the run counter never reaches the exit count while stored
    a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_q < RUN_LAST);

endmodule

// File: rtl/rxpol_decide.sv
module rxpol_decide
    import rxpol_pkg::*;
#(
    parameter int unsigned LOCK_FRAMES = DEF_LOCK_FRAMES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     link_fail,
    input  logic     corr_dis,
    input  pol_evt_t lp,
    input  pol_evt_t eof,
    output logic     invert,
    output logic     locked
);

    localparam int unsigned AW = cnt_w(LOCK_FRAMES);
    localparam logic [AW-1:0] AGR_ONE  = AW'(1);
    localparam logic [AW-1:0] AGR_LOCK = AW'(LOCK_FRAMES);

    logic          inv_q, inv_d;
    logic          lock_q, lock_d;
    logic [AW-1:0] agree_q, agree_d;
    logic          eof_seen;

    assign eof_seen = eof.stb;

    always_comb begin
        inv_d   = inv_q;
        lock_d  = lock_q;
        agree_d = agree_q;
        if (corr_dis) begin
            inv_d   = 1'b0;
            lock_d  = 1'b0;
            agree_d = '0;
        end else if (link_fail) begin
            lock_d  = 1'b0;
            agree_d = '0;
        end else if (!lock_q) begin
            if (eof.stb) begin
                if (evt_agrees(eof, inv_q)) begin
                    agree_d = agree_q + AGR_ONE;
                    if (agree_d == AGR_LOCK) begin
                        lock_d = 1'b1;
                    end
                end else begin
                    inv_d   = eof.neg;
                    agree_d = AGR_ONE;
                end
            end else if (lp.stb) begin
                inv_d = lp.neg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q   <= 1'b0;
            lock_q  <= 1'b0;
            agree_q <= '0;
        end else begin
            inv_q   <= inv_d;
            lock_q  <= lock_d;
            agree_q <= agree_d;
        end
    end

    assign invert = inv_q;
    assign locked = lock_q;

    // R10: disabling correction clears both flags on the next edge
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        corr_dis |=> (!inv_q && !lock_q));

    // R7: a held lock freezes the invert flag
    a_r7_lock_freezes: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !corr_dis && !link_fail) |=> (lock_q && $stable(inv_q)));

    // R8: link failure drops the lock and keeps the invert flag
    a_r8_fail_unlocks: assert property (@(posedge clk) disable iff (rst)
        (link_fail && !corr_dis) |=> (!lock_q && $stable(inv_q)));

    // R6: the lock can only be taken by a frame
    a_r6_lock_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(eof_seen));

endmodule

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl
    import rxpol_pkg::*;
#(
    parameter int unsigned EXIT_PULSES = DEF_EXIT_PULSES,
    parameter int unsigned LOCK_FRAMES = DEF_LOCK_FRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_stb,
    input  logic lp_neg,
    input  logic eof_stb,
    input  logic eof_neg,
    input  logic link_fail,
    input  logic corr_dis,
    output logic rx_invert,
    output logic pol_locked,
    output logic lf_exit_stb
);

    pol_evt_t lp_evt;
    pol_evt_t eof_evt;

    assign lp_evt  = '{stb: lp_stb,  neg: lp_neg};
    assign eof_evt = '{stb: eof_stb, neg: eof_neg};

    rxpol_linkexit #(
        .EXIT_PULSES(EXIT_PULSES)
    ) u_linkexit (
        .clk      (clk),
        .rst      (rst),
        .link_fail(link_fail),
        .lp       (lp_evt),
        .exit_stb (lf_exit_stb)
    );

    rxpol_decide #(
        .LOCK_FRAMES(LOCK_FRAMES)
    ) u_decide (
        .clk      (clk),
        .rst      (rst),
        .link_fail(link_fail),
        .corr_dis (corr_dis),
        .lp       (lp_evt),
        .eof      (eof_evt),
        .invert   (rx_invert),
        .locked   (pol_locked)
    );

    // R1: out of reset the flags start clear
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!rx_invert && !pol_locked && !lf_exit_stb));

endmodule

// File: tb/rxpol_ctrl_test.sv
module rxpol_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_stb = 1'b0, lp_neg = 1'b0, eof_stb = 1'b0, eof_neg = 1'b0;
    logic link_fail = 1'b0, corr_dis = 1'b0;
    logic rx_invert, pol_locked, lf_exit_stb;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    bit mvalid = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    rxpol_ctrl uut (
        .clk(clk), .rst(rst),
        .lp_stb(lp_stb), .lp_neg(lp_neg),
        .eof_stb(eof_stb), .eof_neg(eof_neg),
        .link_fail(link_fail), .corr_dis(corr_dis),
        .rx_invert(rx_invert), .pol_locked(pol_locked),
        .lf_exit_stb(lf_exit_stb)
    );

    // behavioural reference model
    int m_inv, m_lock, m_fail, m_run, m_last, m_agree, m_exit;

    always @(posedge clk) begin
        if (rst) begin
            m_inv = 0; m_lock = 0; m_fail = 1; m_run = 0;
            m_last = 0; m_agree = 0; m_exit = 0;
            mvalid = 1;
        end else begin
            m_exit = 0;
            if (link_fail) begin
                m_fail = 1; m_run = 0;
            end else if (m_fail == 1 && lp_stb) begin
                if (m_run > 0 && int'(lp_neg) == m_last) m_run++;
                else m_run = 1;
                m_last = int'(lp_neg);
                if (m_run == 5) begin
                    m_exit = 1; m_fail = 0; m_run = 0;
                end
            end
            if (corr_dis) begin
                m_inv = 0; m_lock = 0; m_agree = 0;
            end else if (link_fail) begin
                m_lock = 0; m_agree = 0;
            end else if (m_lock == 0) begin
                if (eof_stb) begin
                    if (int'(eof_neg) == m_inv) begin
                        m_agree++;
                        if (m_agree == 2) m_lock = 1;
                    end else begin
                        m_inv = int'(eof_neg); m_agree = 1;
                    end
                end else if (lp_stb) begin
                    m_inv = int'(lp_neg);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mvalid && !done) begin
            chk(rx_invert,   logic'(m_inv  != 0), cur_req, "model rx_invert");
            chk(pol_locked,  logic'(m_lock != 0), cur_req, "model pol_locked");
            chk(lf_exit_stb, logic'(m_exit != 0), cur_req, "model lf_exit_stb");
        end
    end

    // apply inputs for one cycle, return just after the next falling edge
    task automatic tick(input logic lp, input logic lpn, input logic ef, input logic efn,
                        input logic lf);
        lp_stb = lp; lp_neg = lpn; eof_stb = ef; eof_neg = efn; link_fail = lf;
        @(negedge clk); #1;
        lp_stb = 0; eof_stb = 0; link_fail = 0;
    endtask

    task automatic pulse(input logic n);  tick(1, n, 0, 0, 0); endtask
    task automatic frame(input logic n);  tick(0, 0, 1, n, 0); endtask
    task automatic idle();                tick(0, 0, 0, 0, 0); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1 reset state
        cur_req = "R1";
        chk(rx_invert, 0, "R1", "invert after reset");
        chk(pol_locked, 0, "R1", "locked after reset");
        chk(lf_exit_stb, 0, "R1", "exit after reset");

        // R2 / R5: five reversed pulses leave the failed condition
        cur_req = "R2";
        for (int i = 0; i < 4; i++) begin
            pulse(1);
            chk(lf_exit_stb, 0, "R2", "no exit before fifth pulse");
        end
        chk(rx_invert, 1, "R5", "invert follows pulse");
        pulse(1);
        chk(lf_exit_stb, 1, "R2", "exit after fifth pulse");
        idle();
        chk(lf_exit_stb, 0, "R2", "exit lasts one cycle");

        // R4: pulses while link is up
        cur_req = "R4";
        for (int i = 0; i < 6; i++) begin
            pulse(1);
            chk(lf_exit_stb, 0, "R4", "no exit while up");
        end
        cur_req = "R5";
        pulse(0);
        chk(rx_invert, 0, "R5", "pulse clears invert");

        // R6: two agreeing frames lock
        cur_req = "R6";
        frame(1);
        chk(rx_invert, 1, "R6", "disagreeing frame loads invert");
        chk(pol_locked, 0, "R6", "one frame does not lock");
        frame(1);
        chk(pol_locked, 1, "R6", "second agreeing frame locks");

        // R7: locked ignores evidence
        cur_req = "R7";
        frame(0);
        pulse(0);
        chk(rx_invert, 1, "R7", "invert frozen while locked");
        chk(pol_locked, 1, "R7", "lock held");

        // R8: link failure unlocks, keeps invert, ignores strobes
        cur_req = "R8";
        tick(0, 0, 1, 0, 1);
        chk(pol_locked, 0, "R8", "fail clears lock");
        chk(rx_invert, 1, "R8", "fail keeps invert");

        // R3: polarity change restarts the run
        cur_req = "R3";
        pulse(1); pulse(1); pulse(1);
        for (int i = 0; i < 4; i++) pulse(0);
        chk(lf_exit_stb, 0, "R3", "mixed run gives no exit");
        pulse(0);
        chk(lf_exit_stb, 1, "R3", "exit after five same after change");
        chk(rx_invert, 0, "R5", "invert follows last pulse");
        idle();

        // R6: alternating delimiters restart the agreement count
        cur_req = "R6";
        frame(1); frame(0); frame(1);
        chk(pol_locked, 0, "R6", "alternating frames stay unlocked");
        chk(rx_invert, 1, "R6", "last frame sets invert");
        frame(1);
        chk(pol_locked, 1, "R6", "lock after restart");

        // R10: disable
        cur_req = "R10";
        corr_dis = 1;
        idle();
        chk(rx_invert, 0, "R10", "disable clears invert");
        chk(pol_locked, 0, "R10", "disable clears lock");
        frame(1); frame(1);
        chk(rx_invert, 0, "R10", "invert held off while disabled");
        chk(pol_locked, 0, "R10", "no lock while disabled");
        tick(0, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) pulse(0);
        chk(lf_exit_stb, 1, "R10", "exit works while disabled");
        corr_dis = 0;
        idle();
        frame(1); frame(1);
        chk(pol_locked, 1, "R10", "lock resumes after enable");

        // R9: both strobes in one cycle
        cur_req = "R9";
        tick(0, 0, 0, 0, 1);
        tick(1, 1, 1, 0, 0);
        chk(rx_invert, 0, "R9", "frame wins over pulse");
        tick(1, 1, 1, 0, 0);
        chk(pol_locked, 1, "R9", "lock from simultaneous strobes");
        chk(rx_invert, 0, "R9", "invert after lock");

        // R11: reset from locked state
        cur_req = "R11";
        frame(1);
        rst = 1;
        idle();
        rst = 0;
        chk(rx_invert, 0, "R11", "reset clears invert");
        chk(pol_locked, 0, "R11", "reset clears lock");
        for (int i = 0; i < 5; i++) pulse(1);
        chk(lf_exit_stb, 1, "R11", "link failed again after reset");
        idle();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule